// File: doc/BRIEF.md
# UART Interrupt Enable and Routing Controller

This block decides which UART conditions reach the interrupt controller. It holds a three-bit enable mask that software never writes as a whole. One bus address sets mask bits and a second bus address clears them. Because of this, separate handlers for receive, transmit and line errors can each change their own bit without a read-modify-write sequence that could race against another handler.

The block takes three kinds of status from the rest of the UART: a receive-data-ready level, a transmit-holding-empty level, and single-cycle event pulses for overrun, parity, framing and break errors. It latches the error events into sticky flags, gates each request with its enable bit, and drives three registered level interrupts: receive, transmit and line status. A control bit can merge the receive and transmit requests onto the line-status output. This serves systems that give the UART only one interrupt line.

The register bus is a plain synchronous port. A write takes effect on the clock edge at which `bus_wr` is sampled high. Read data is combinational from the current address. The serializer, baud generator, FIFOs and DMA sit outside this block. Line-status gating behaves the same whether or not DMA moves the data.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable mask is 000, the reroute bit is 0, and `irq_rx`, `irq_tx` and `irq_ls` are low.
- R2: A write to address 0 (set) ORs `bus_wdata[2:0]` into the mask. Mask bit 0 enables receive, bit 1 enables transmit and bit 2 enables line status. Zero bits in the write leave their mask bits unchanged.
- R3: A write to address 1 (clear) clears every mask bit whose `bus_wdata` bit is one. Zero bits in the write leave their mask bits unchanged.
- R4: Reading address 0 or address 1 returns the mask in bits 2:0, with all higher bits zero. Write data bits above bit 2 have no effect. Address 2 holds the reroute bit in bit 0; it is written directly and reads back the same way. Every other address reads as zero, and writes to it do nothing.
- R5: `irq_rx` is high in the cycle after an edge at which `rx_ready` and mask bit 0 were both high and reroute was low. Otherwise it is low in that cycle.
- R6: `irq_tx` is high in the cycle after an edge at which `tx_empty` and mask bit 1 were both high and reroute was low. Otherwise it is low in that cycle.
- R7: A pulse on any bit of `err_evt` (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) sets a sticky error state on the next edge. The state holds until a `clr_status` pulse. `irq_ls` is high one cycle after an edge at which the sticky state and mask bit 2 were both set.
- R8: If an `err_evt` pulse and a `clr_status` pulse arrive in the same cycle, the sticky error state remains set.
- R9: While reroute is 1, `irq_rx` and `irq_tx` stay low. In that mode `irq_ls` is the OR of the enabled receive, transmit and line-status requests, with the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| rx_ready | input | 1 | Receive data ready level |
| tx_empty | input | 1 | Transmit holding register empty level |
| err_evt | input | ERR_N | Line-error event pulses |
| clr_status | input | 1 | Software clear of the sticky error state |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_ls | output | 1 | Line-status interrupt (merged requests when rerouted) |

## Verification
Two functions can fall in the same cycle: a new line-error event and a software clear of the sticky error state. Only one outcome keeps the error, and that is the one required. The bench drives an `err_evt` pulse and `clr_status` together, then checks that `irq_ls` stays high two cycles later. Its behavioural model updates the flag so that the event wins. A second collision changes the reroute bit while requests are active; this checks that the dedicated outputs and the status output swap in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int MASK_W     = 3;
  localparam int BIT_RX     = 0;
  localparam int BIT_TX     = 1;
  localparam int BIT_LS     = 2;
  localparam int A_EN_SET   = 0;
  localparam int A_EN_CLR   = 1;
  localparam int A_GLOBAL   = 2;
  localparam int BIT_REROUTE = 0;

  typedef struct packed {
    logic ls;
    logic tx;
    logic rx;
  } irq_req_t;
endpackage

// File: rtl/uirq_regbank.sv
module uirq_regbank
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [MASK_W-1:0] en_mask,
  output logic              reroute
);
  localparam int PAD_W = DATA_W - MASK_W;

  logic hit_set, hit_clr, hit_glb;
  logic [MASK_W-1:0] wbits;

  assign hit_set = (bus_addr == ADDR_W'(A_EN_SET));
  assign hit_clr = (bus_addr == ADDR_W'(A_EN_CLR));
  assign hit_glb = (bus_addr == ADDR_W'(A_GLOBAL));
  assign wbits   = bus_wdata[MASK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0;
      reroute <= 1'b0;
    end else if (bus_wr) begin
      if (hit_set) en_mask <= en_mask | wbits;
      if (hit_clr) en_mask <= en_mask & ~wbits;
      if (hit_glb) reroute <= bus_wdata[BIT_REROUTE];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_set || hit_clr) bus_rdata = {{PAD_W{1'b0}}, en_mask};
    else if (hit_glb)       bus_rdata[BIT_REROUTE] = reroute;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_set) |=> ((en_mask & $past(wbits)) == $past(wbits)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_clr) |=> ((en_mask & $past(wbits)) == '0));
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (hit_set || hit_clr)) |=> $stable(en_mask));
endmodule

// File: rtl/uirq_err_sticky.sv
module uirq_err_sticky #(
  parameter int ERR_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] err_evt,
  input  logic             clr_status,
  output logic             any_err
);
  logic [ERR_N-1:0] flag;

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag[i] <= 1'b0;
      else if (err_evt[i]) flag[i] <= 1'b1;
      else if (clr_status) flag[i] <= 1'b0;
    end
  end

  assign any_err = |flag;

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> any_err);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !clr_status) |=> any_err);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !(|err_evt)) |=> !any_err);
endmodule

// File: rtl/uirq_route.sv
module uirq_route
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] en_mask,
  input  logic              reroute,
  input  logic              rx_ready,
  input  logic              tx_empty,
  input  logic              any_err,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_ls
);
  irq_req_t req;

  always_comb begin
    req.rx = en_mask[BIT_RX] & rx_ready;
    req.tx = en_mask[BIT_TX] & tx_empty;
    req.ls = en_mask[BIT_LS] & any_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
      irq_ls <= 1'b0;
    end else if (reroute) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
      irq_ls <= |req;
    end else begin
      irq_rx <= req.rx;
      irq_tx <= req.tx;
      irq_ls <= req.ls;
    end
  end

  p_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask[BIT_RX] && rx_ready && !reroute) |=> irq_rx);
  p_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask[BIT_TX] && tx_empty && !reroute) |=> irq_tx);
  p_ls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask[BIT_LS] && any_err) |=> irq_ls);
  p_reroute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reroute |=> (!irq_rx && !irq_tx));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ERR_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_ready,
  input  logic              tx_empty,
  input  logic [ERR_N-1:0]  err_evt,
  input  logic              clr_status,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_ls
);
  logic [MASK_W-1:0] en_mask;
  logic              reroute;
  logic              any_err;

  uirq_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_mask(en_mask), .reroute(reroute)
  );

  uirq_err_sticky #(.ERR_N(ERR_N)) err_i (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt),
    .clr_status(clr_status), .any_err(any_err)
  );

  uirq_route route_i (
    .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .reroute(reroute),
    .rx_ready(rx_ready), .tx_empty(tx_empty), .any_err(any_err),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ls(irq_ls)
  );

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq_rx && !irq_tx && !irq_ls));
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ERR_N  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              rx_ready = 1'b0;
  logic              tx_empty = 1'b0;
  logic [ERR_N-1:0]  err_evt = '0;
  logic              clr_status = 1'b0;
  logic              irq_rx, irq_tx, irq_ls;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_N(ERR_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
    .tx_empty(tx_empty), .err_evt(err_evt), .clr_status(clr_status),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ls(irq_ls)
  );

  // Behavioural model state
  int m_mask = 0;
  int m_rer  = 0;
  int m_flag = 0;
  int e_rx = 0, e_tx = 0, e_ls = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int model_rdata(input int addr);
    if (addr == 0 || addr == 1) return m_mask;
    if (addr == 2) return m_rer;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_rer = 0; m_flag = 0;
      e_rx = 0; e_tx = 0; e_ls = 0;
    end else begin
      int rq_rx, rq_tx, rq_ls;
      rq_rx = (m_mask & 1) != 0 && rx_ready;
      rq_tx = (m_mask & 2) != 0 && tx_empty;
      rq_ls = (m_mask & 4) != 0 && m_flag != 0;
      if (m_rer != 0) begin
        e_rx = 0; e_tx = 0; e_ls = (rq_rx || rq_tx || rq_ls) ? 1 : 0;
      end else begin
        e_rx = rq_rx; e_tx = rq_tx; e_ls = rq_ls;
      end
      if (bus_wr) begin
        if (bus_addr == 0) m_mask = m_mask | (int'(bus_wdata) & 7);
        if (bus_addr == 1) m_mask = m_mask & ~(int'(bus_wdata) & 7);
        if (bus_addr == 2) m_rer = int'(bus_wdata[0]);
      end
      if (err_evt != 0) m_flag = 1;
      else if (clr_status) m_flag = 0;
    end
    #3;
    check("R5/R1 irq_rx", int'(irq_rx), e_rx);
    check("R6/R9 irq_tx", int'(irq_tx), e_tx);
    check("R7/R9 irq_ls", int'(irq_ls), e_ls);
    check("R4 bus_rdata", int'(bus_rdata), model_rdata(int'(bus_addr)));
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 check(req, int'(bus_rdata), exp);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    // R1: reset state
    check("R1 irq_rx reset", int'(irq_rx), 0);
    check("R1 irq_ls reset", int'(irq_ls), 0);
    rst_n = 1'b1;
    rd_check("R1 mask reset", 0, 0);
    rx_ready = 1'b1; tx_empty = 1'b1;
    step(3);
    // R2: set receive enable only
    wr(0, 1);
    rd_check("R2 set rx", 1, 1);
    step(2);
    check("R5 irq_rx enabled", int'(irq_rx), 1);
    check("R6 irq_tx still off", int'(irq_tx), 0);
    // R4: upper bits ignored, R2 zeros keep
    wr(0, 8'hFA);
    rd_check("R4 upper bits ignored", 0, 3);
    step(2);
    check("R6 irq_tx enabled", int'(irq_tx), 1);
    rx_ready = 1'b0;
    step(2);
    check("R5 irq_rx follows ready", int'(irq_rx), 0);
    // R3: clear transmit only
    wr(1, 2);
    rd_check("R3 clear tx", 0, 1);
    rd_check("R4 other addr", 7, 0);
    wr(7, 8'hFF);
    rd_check("R4 ignored addr write", 1, 1);
    // R7: line status
    wr(0, 4);
    @(negedge clk); err_evt = 4'b0100;
    @(negedge clk); err_evt = '0;
    step(4);
    check("R7 sticky holds irq_ls", int'(irq_ls), 1);
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
    step(2);
    check("R7 cleared", int'(irq_ls), 0);
    // R8: event and clear collide
    @(negedge clk); err_evt = 4'b1001; clr_status = 1'b1;
    @(negedge clk); err_evt = '0; clr_status = 1'b0;
    step(3);
    check("R8 event wins", int'(irq_ls), 1);
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
    step(2);
    // R9: reroute
    rx_ready = 1'b1;
    wr(2, 1);
    rd_check("R9 reroute readback", 2, 1);
    step(2);
    check("R9 rx muted", int'(irq_rx), 0);
    check("R9 merged on ls", int'(irq_ls), 1);
    wr(1, 1);
    step(2);
    check("R9 nothing enabled", int'(irq_ls), 0);
    tx_empty = 1'b1;
    wr(0, 2);
    step(2);
    check("R9 tx merged", int'(irq_ls), 1);
    wr(2, 0);
    step(2);
    check("R6 back on own line", int'(irq_tx), 1);
    check("R9 ls released", int'(irq_ls), 0);
    wr(1, 8'hFF);
    rd_check("R3 clear all", 1, 0);
    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule